// File: doc/BRIEF.md
# Segment Descriptor Load Checker

This block decides whether a descriptor fetched from one of the three descriptor tables may be loaded into a given destination. The destination can be a segment register (code, two data registers, stack), the local-table register, the task register, or a control transfer through a gate. The caller supplies the descriptor's access byte, the destination, the source table and a flag that marks a null selector. Privilege levels are not examined; the DPL bits pass through unused.

One cycle after an input strobe the block returns a registered verdict. The verdict holds a legal flag, a class code for the descriptor, a busy flag for task-state descriptors and a clear-interrupt flag for interrupt gates. A load that is not legal is a general-protection fault with error code zero. The caller raises that fault from `out_valid & ~out_legal`. Outputs hold their last verdict between strobes.

Access byte layout: bit 7 = present, bits 6:5 = DPL (ignored), bit 4 = segment flag S (1 = code/data, 0 = system). For S=1, bit 3 = executable, bit 1 = readable (code) or writable (data). For S=0, bits 3:0 hold the system type. Destination codes are 0 CS, 1 DS, 2 ES, 3 SS, 4 local-table register, 5 task register, 6 gate transfer, and 7 unused. Table codes are 0 global, 1 local, 2 interrupt, and 3 reserved.

Top module: `seg_load_checker`

## Requirements
- R1: Destination 0 (CS) is legal only for S=1 with bit 3 (executable) set; bit 1 has no effect.
- R2: Destination 3 (SS) is legal only for S=1 with bit 3 clear and bit 1 (writable) set.
- R3: Destinations 1 and 2 are legal for any S=1 data segment, and for an S=1 code segment only when bit 1 (readable) is set.
- R4: out_class encodes the descriptor. The codes are 1 code and 2 data (S=1). For S=0 they are: 3 for a 16-bit TSS (types 1, 3), 4 for a 32-bit TSS (types 9, B), 5 for a local table (type 2), 6 and 7 for 16/32-bit call gates (types 4, C), and 8 for a task gate (type 5). Interrupt gates are 9 (type 6) and 11 (type E), and trap gates are 10 (type 7) and 12 (type F). Types 0, 8, A and D give 15 (invalid). Code 0 marks a null selector.
- R5: out_clear_if is 1 for interrupt-gate classes (9, 11) and 0 for trap gates and every other class.
- R6: Table placement applies. TSS and local-table descriptors are legal only from table 0. Interrupt and trap gates are legal only from table 2. Task gates are legal from tables 0, 1 and 2. Call gates and code/data segments are legal from tables 0 and 1.
- R7: Destination 4 is legal only for class 5. Destination 5 is legal only for type 1 or 9 (available TSS). out_busy equals type bit 1 for TSS classes and is 0 otherwise.
- R8: A descriptor with bit 7 (present) clear is never legal.
- R9: Destination 6 is legal only for gate classes 6 to 12.
- R10: With in_null_sel set, the access byte and table are ignored. Destinations 1 and 2 are legal and all others fault; out_class is 0, and out_busy and out_clear_if are 0.
- R11: Reset gives out_valid=0, out_legal=0, out_class=0, out_busy=0 and out_clear_if=0. out_valid is 1 exactly one cycle after in_valid. Without a strobe the other outputs hold.
- R12: Table code 3, destination code 7 and invalid class 15 always fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_access | input | 8 | Descriptor access byte |
| in_target | input | 3 | Load destination code |
| in_table | input | 2 | Source table code |
| in_null_sel | input | 1 | Selector is the null selector |
| out_valid | output | 1 | Verdict strobe, one cycle after in_valid |
| out_legal | output | 1 | Load is legal; 0 with out_valid means GP fault, code 0 |
| out_class | output | 4 | Descriptor class code |
| out_busy | output | 1 | TSS busy flag |
| out_clear_if | output | 1 | Interrupt gate: clear interrupt enable on entry |

## Verification
The bench sweeps every access byte against every destination and table code. This covers execute-only code into data registers, read-only data into the stack register, and busy TSS into the task register. A design that ignored the readable bit would accept execute-only code through DS, and one that checked the writable bit for CS would reject valid code. Placement corners include gates from the wrong table and a TSS from the local table; a missing table check would accept them silently. Null selectors with garbage access bytes are also exercised, along with idle gaps between strobes, so a design that decoded the access byte under a null selector, or let outputs drift without a strobe, shows up as a mismatch.

// File: rtl/seg_load_pkg.sv
// Shared codes for the descriptor load checker. Assumes the access-byte
// layout described in the brief; all other modules import this package.
package seg_load_pkg;

    localparam int ACC_W   = 8;
    localparam int TGT_W   = 3;
    localparam int TBL_W   = 2;
    localparam int CLS_W   = 4;

    // access-byte bit positions
    localparam int BIT_P   = 7;
    localparam int BIT_S   = 4;
    localparam int BIT_X   = 3;
    localparam int BIT_RW  = 1;
    localparam int TYPE_W  = 4;

    typedef enum logic [TGT_W-1:0] {
        TGT_CS   = 3'd0,
        TGT_DS   = 3'd1,
        TGT_ES   = 3'd2,
        TGT_SS   = 3'd3,
        TGT_LDTR = 3'd4,
        TGT_TR   = 3'd5,
        TGT_GATE = 3'd6,
        TGT_NONE = 3'd7
    } target_e;

    typedef enum logic [TBL_W-1:0] {
        TBL_GLOBAL = 2'd0,
        TBL_LOCAL  = 2'd1,
        TBL_INTR   = 2'd2,
        TBL_RSVD   = 2'd3
    } table_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_NULL    = 4'd0,
        CLS_CODE    = 4'd1,
        CLS_DATA    = 4'd2,
        CLS_TSS16   = 4'd3,
        CLS_TSS32   = 4'd4,
        CLS_LTAB    = 4'd5,
        CLS_CALL16  = 4'd6,
        CLS_CALL32  = 4'd7,
        CLS_TASKG   = 4'd8,
        CLS_INT16   = 4'd9,
        CLS_TRAP16  = 4'd10,
        CLS_INT32   = 4'd11,
        CLS_TRAP32  = 4'd12,
        CLS_INVALID = 4'd15
    } class_e;

endpackage

// File: rtl/seg_type_decode.sv
// Classifies a descriptor from its access byte. Purely combinational.
// Assumes the caller handles the null selector separately.
module seg_type_decode
    import seg_load_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    output class_e           cls,
    output logic             busy,
    output logic             clr_if
);

    // map segment flag and type nibble to a class code
    always_comb begin
        cls = CLS_INVALID;
        if (acc[BIT_S]) begin
            cls = acc[BIT_X] ? CLS_CODE : CLS_DATA;
        end else begin
            case (acc[TYPE_W-1:0])
                4'h1, 4'h3: cls = CLS_TSS16;
                4'h9, 4'hB: cls = CLS_TSS32;
                4'h2:       cls = CLS_LTAB;
                4'h4:       cls = CLS_CALL16;
                4'hC:       cls = CLS_CALL32;
                4'h5:       cls = CLS_TASKG;
                4'h6:       cls = CLS_INT16;
                4'h7:       cls = CLS_TRAP16;
                4'hE:       cls = CLS_INT32;
                4'hF:       cls = CLS_TRAP32;
                default:    cls = CLS_INVALID;
            endcase
        end
    end

    // busy bit of task-state descriptors, interrupt-flag clearing of gates
    always_comb begin
        busy   = ((cls == CLS_TSS16) || (cls == CLS_TSS32)) && acc[BIT_RW];
        clr_if = (cls == CLS_INT16) || (cls == CLS_INT32);
    end

endmodule

// File: rtl/seg_table_check.sv
// Decides whether a descriptor class may reside in the given table.
// Combinational; the reserved table code never passes.
module seg_table_check
    import seg_load_pkg::*;
(
    input  class_e cls,
    input  table_e tbl,
    output logic   ok
);

    // placement rules per class
    always_comb begin
        ok = 1'b0;
        unique case (cls)
            CLS_CODE, CLS_DATA, CLS_CALL16, CLS_CALL32:
                ok = (tbl == TBL_GLOBAL) || (tbl == TBL_LOCAL);
            CLS_TSS16, CLS_TSS32, CLS_LTAB:
                ok = (tbl == TBL_GLOBAL);
            CLS_TASKG:
                ok = (tbl != TBL_RSVD);
            CLS_INT16, CLS_TRAP16, CLS_INT32, CLS_TRAP32:
                ok = (tbl == TBL_INTR);
            default:
                ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_target_check.sv
// Decides whether a descriptor class and its attribute bits suit the load
// destination. Combinational; presence and placement are checked elsewhere.
module seg_target_check
    import seg_load_pkg::*;
(
    input  target_e          tgt,
    input  logic [ACC_W-1:0] acc,
    input  class_e           cls,
    output logic             ok
);

    logic is_gate;

    // gate classes usable for a control transfer
    always_comb begin
        is_gate = (cls == CLS_CALL16) || (cls == CLS_CALL32) ||
                  (cls == CLS_TASKG)  || (cls == CLS_INT16)  ||
                  (cls == CLS_TRAP16) || (cls == CLS_INT32)  ||
                  (cls == CLS_TRAP32);
    end

    // destination compatibility matrix
    always_comb begin
        ok = 1'b0;
        unique case (tgt)
            TGT_CS:         ok = (cls == CLS_CODE);
            TGT_DS, TGT_ES: ok = (cls == CLS_DATA) ||
                                 ((cls == CLS_CODE) && acc[BIT_RW]);
            TGT_SS:         ok = (cls == CLS_DATA) && acc[BIT_RW];
            TGT_LDTR:       ok = (cls == CLS_LTAB);
            TGT_TR:         ok = ((cls == CLS_TSS16) || (cls == CLS_TSS32)) &&
                                 !acc[BIT_RW];
            TGT_GATE:       ok = is_gate;
            default:        ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_load_checker.sv
// Top of the descriptor load checker. Combines type decode, table placement
// and destination checks, applies presence and null-selector rules, and
// registers the verdict one cycle after each strobe. Assumes a synchronous
// active-low reset; a non-legal verdict means a GP fault with code zero.
module seg_load_checker
    import seg_load_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] in_access,
    input  logic [TGT_W-1:0] in_target,
    input  logic [TBL_W-1:0] in_table,
    input  logic             in_null_sel,
    output logic             out_valid,
    output logic             out_legal,
    output logic [CLS_W-1:0] out_class,
    output logic             out_busy,
    output logic             out_clear_if
);

    class_e  dec_cls;
    logic    dec_busy;
    logic    dec_clr;
    logic    tbl_ok;
    logic    tgt_ok;
    logic    nxt_legal;
    class_e  nxt_cls;
    logic    nxt_busy;
    logic    nxt_clr;
    target_e tgt;
    table_e  tbl;

    // cast raw port codes to package enums
    always_comb begin
        tgt = target_e'(in_target);
        tbl = table_e'(in_table);
    end

    seg_type_decode u_decode (
        .acc    (in_access),
        .cls    (dec_cls),
        .busy   (dec_busy),
        .clr_if (dec_clr)
    );

    seg_table_check u_table (
        .cls (dec_cls),
        .tbl (tbl),
        .ok  (tbl_ok)
    );

    seg_target_check u_target (
        .tgt (tgt),
        .acc (in_access),
        .cls (dec_cls),
        .ok  (tgt_ok)
    );

    // merge checks; a null selector bypasses the descriptor entirely
    always_comb begin
        if (in_null_sel) begin
            nxt_legal = (tgt == TGT_DS) || (tgt == TGT_ES);
            nxt_cls   = CLS_NULL;
            nxt_busy  = 1'b0;
            nxt_clr   = 1'b0;
        end else begin
            nxt_legal = in_access[BIT_P] && tbl_ok && tgt_ok;
            nxt_cls   = dec_cls;
            nxt_busy  = dec_busy;
            nxt_clr   = dec_clr;
        end
    end

    // verdict register, loaded only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_legal    <= 1'b0;
            out_class    <= CLS_NULL;
            out_busy     <= 1'b0;
            out_clear_if <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_legal    <= nxt_legal;
                out_class    <= nxt_cls;
                out_busy     <= nxt_busy;
                out_clear_if <= nxt_clr;
            end
        end
    end

endmodule

// File: rtl/seg_load_checker_sva.sv
// Property checker for the descriptor load checker, bound to the top.
module seg_load_checker_sva
    import seg_load_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [ACC_W-1:0] in_access,
    input logic [TGT_W-1:0] in_target,
    input logic [TBL_W-1:0] in_table,
    input logic             in_null_sel,
    input logic             out_valid,
    input logic             out_legal,
    input logic [CLS_W-1:0] out_class,
    input logic             out_busy,
    input logic             out_clear_if
);

    AST_CS_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_null_sel && in_target == 3'd0 && !in_access[BIT_X]
        |=> out_valid && !out_legal); // R1

    AST_SS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_null_sel && in_target == 3'd3 &&
        (!in_access[BIT_S] || in_access[BIT_X] || !in_access[BIT_RW])
        |=> !out_legal); // R2

    AST_NOT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_null_sel && !in_access[BIT_P]
        |=> out_valid && !out_legal); // R8

    AST_GATE_IDT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_null_sel && in_table != 2'd2 && !in_access[BIT_S] &&
        in_access[2:1] == 2'b11
        |=> !out_legal); // R6

    AST_CLEAR_IF_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_clear_if |-> (out_class == CLS_INT16 || out_class == CLS_INT32)); // R5

    AST_BUSY_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_busy |-> (out_class == CLS_TSS16 || out_class == CLS_TSS32)); // R7

    AST_NULL_DATA_OK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_null_sel && (in_target == 3'd1 || in_target == 3'd2)
        |=> out_legal && out_class == CLS_NULL); // R10

    AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_class) && $stable(out_legal)); // R11

endmodule

bind seg_load_checker seg_load_checker_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_access    (in_access),
    .in_target    (in_target),
    .in_table     (in_table),
    .in_null_sel  (in_null_sel),
    .out_valid    (out_valid),
    .out_legal    (out_legal),
    .out_class    (out_class),
    .out_busy     (out_busy),
    .out_clear_if (out_clear_if)
);

// File: tb/seg_load_checker_bench.sv
// Bench: behavioural reference model compared against the outputs every clock.
module seg_load_checker_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_access = 8'h00;
    logic [2:0] in_target = 3'd0;
    logic [1:0] in_table = 2'd0;
    logic       in_null_sel = 1'b0;
    logic       out_valid, out_legal, out_busy, out_clear_if;
    logic [3:0] out_class;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    // expected registered state and the pending request
    bit    e_v = 0, e_l = 0, e_b = 0, e_i = 0;
    int    e_c = 0;
    string e_tag = "R11";
    bit    p_v = 0, p_l = 0, p_b = 0, p_i = 0;
    int    p_c = 0;
    string p_tag = "R11";

    always #2 clk = ~clk;

    seg_load_checker u_seg_load_checker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_access(in_access),
        .in_target(in_target), .in_table(in_table), .in_null_sel(in_null_sel),
        .out_valid(out_valid), .out_legal(out_legal), .out_class(out_class),
        .out_busy(out_busy), .out_clear_if(out_clear_if)
    );

    // reference classification from the R4 code list
    function automatic int ref_class(input logic [7:0] a);
        if (a[4]) return a[3] ? 1 : 2;
        case (int'(a[3:0]))
            1, 3:    return 3;
            9, 11:   return 4;
            2:       return 5;
            4:       return 6;
            12:      return 7;
            5:       return 8;
            6:       return 9;
            7:       return 10;
            14:      return 11;
            15:      return 12;
            default: return 15;
        endcase
    endfunction

    // reference verdict per R1..R12
    task automatic model(input logic [7:0] a, input int tg, input int tb,
                         input bit nul, output bit lg, output int c,
                         output bit b, output bit ci, output string tag);
        bit place, fit;
        if (nul) begin
            c = 0; b = 0; ci = 0;
            lg = (tg == 1 || tg == 2);
            tag = "R10";
            return;
        end
        c  = ref_class(a);
        b  = (c == 3 || c == 4) && a[1];
        ci = (c == 9 || c == 11);
        if (c == 1 || c == 2 || c == 6 || c == 7) place = (tb == 0 || tb == 1);
        else if (c == 3 || c == 4 || c == 5)     place = (tb == 0);
        else if (c == 8)                         place = (tb != 3);
        else if (c >= 9 && c <= 12)              place = (tb == 2);
        else                                     place = 0;
        case (tg)
            0:       begin fit = (c == 1);                          tag = "R1"; end
            1, 2:    begin fit = (c == 2) || (c == 1 && a[1]);      tag = "R3"; end
            3:       begin fit = (c == 2) && a[1];                  tag = "R2"; end
            4:       begin fit = (c == 5);                          tag = "R7"; end
            5:       begin fit = (c == 3 || c == 4) && !a[1];       tag = "R7"; end
            6:       begin fit = (c >= 6 && c <= 12);               tag = "R9"; end
            default: begin fit = 0;                                 tag = "R12"; end
        endcase
        if (!place) tag = "R6";
        if (tb == 3 || c == 15) tag = "R12";
        if (!a[7]) tag = "R8";
        lg = a[7] && place && fit;
    endtask

    // compare at the negedge, then apply the next request
    task automatic step(input bit v, input logic [7:0] a, input int tg,
                        input int tb, input bit nul);
        @(negedge clk);
        e_v = p_v;
        if (p_v) begin
            e_l = p_l; e_c = p_c; e_b = p_b; e_i = p_i; e_tag = p_tag;
        end
        compared++;
        if (out_valid !== e_v || out_legal !== e_l || int'(out_class) != e_c ||
            out_busy !== e_b || out_clear_if !== e_i) begin
            string t;
            mismatched++;
            if (out_valid !== e_v)          t = "R11";
            else if (int'(out_class) != e_c) t = "R4";
            else if (out_clear_if !== e_i)  t = "R5";
            else if (out_busy !== e_b)      t = "R7";
            else                            t = e_tag;
            $display("FAIL %s: got v=%0b l=%0b c=%0d b=%0b i=%0b exp v=%0b l=%0b c=%0d b=%0b i=%0b",
                     t, out_valid, out_legal, out_class, out_busy, out_clear_if,
                     e_v, e_l, e_c, e_b, e_i);
        end
        in_valid = v; in_access = a; in_target = 3'(tg);
        in_table = 2'(tb); in_null_sel = nul;
        p_v = v;
        if (v) model(a, tg, tb, nul, p_l, p_c, p_b, p_i, p_tag);
    endtask

    // watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            mismatched++;
            $display("FAIL R11: watchdog expired got cycles=%0d exp below 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state (expected state already zero)
        step(0, 8'h00, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        // full sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 R12, with idle gaps for R11
        for (int a = 0; a < 256; a++) begin
            for (int tg = 0; tg < 8; tg++) begin
                for (int tb = 0; tb < 4; tb++) begin
                    step(1, 8'(a), tg, tb, 0);
                    if (((a + tg + tb) % 7) == 0) step(0, 8'hFF, 6, 2, 1);
                end
            end
        end
        // R10: null selector with arbitrary access bytes and tables
        for (int tg = 0; tg < 8; tg++) begin
            step(1, 8'h00, tg, 0, 1);
            step(1, 8'hFE, tg, 3, 1);
            step(1, 8'h8E, tg, 2, 1);
        end
        // R11: idle after activity holds outputs
        step(1, 8'h9B, 0, 0, 0);
        repeat (4) step(0, 8'h00, 7, 3, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule